// File: doc/BRIEF.md
# Read Eye Centering Training Controller

This block trains the read path of a DDR memory interface. It places the read strobe in the middle of the data eye on every byte lane at once. When it sees a start pulse it writes a fixed training byte to memory on all lanes. It then reads the byte back and checks that the starting delay code already captures it. Each lane then walks its strobe delay code downwards until the compare fails, which gives the lowest passing code. It walks upwards from the starting code in the same way, which gives the highest passing code. The lane sets its delay halfway between the two and runs one more read to confirm it.

All lanes share one command stream. Every read the sequencer issues is evaluated by each lane that is still training. A lane that has finished, whether it passed or failed, keeps its delay code and its flags. The run ends when no lane still needs a read. Each lane reports its error flag, its warning flag and a 4-bit stage code. The result is written to two delay registers per lane, one for the true strobe and one for the complement strobe. A wrapper above this block loads those codes into the real delay lines.

Top module: `rdeye_train`

## Requirements
- R1: After reset, `train_done`, `train_err`, `cmd_valid`, every `lane_err` and every `lane_warn` bit are 0, and every lane delay code equals `INIT_CODE` (default 256).
- R2: A start pulse seen while idle clears `train_done`, all lane flags and all stage codes. Exactly one cycle later it issues one write command (`cmd_valid`=1, `cmd_write`=1) carrying `PATTERN` (default 8'hA5) on every lane. After that, only read commands (`cmd_write`=0) follow in that run.
- R3: A start pulse during a run has no effect: it causes no new write command, and it does not change the run's results.
- R4: A lane reads as passing when its byte of `rd_data` equals `PATTERN`. If the first read, taken at `INIT_CODE`, fails on a lane, that lane sets its error flag, records stage code 4'b0000, keeps its delay at `INIT_CODE` and takes no further part in the run.
- R5: The left edge is the lowest passing code, found by stepping down from `INIT_CODE`-1. The right edge is the highest passing code, found by stepping up from `INIT_CODE`+1. The lane then loads (left + right) >> 1 into both `dqs_dly` and `dqsn_dly`.
- R6: A lane sets its warning flag when its downward search passes at code 0, or its upward search passes at code 511. The edge is then taken as that limit code.
- R7: If the confirm read at the centered code fails, the lane sets its error flag and records stage code 4'b0101. It keeps the centered code and any warning it has already set.
- R8: A read command follows the write command by at least `SETTLE`+1 cycles. It follows the previous read response by at least `SETTLE`+1 cycles.
- R9: `train_done` rises only once every lane has either passed its confirm read or failed. This includes runs where lanes failed. It stays high until the next accepted start.
- R10: `train_err` is 1 exactly when at least one lane error flag is set.
- R11: At most one command is in flight. A command is asserted for a single cycle, and the next read is issued only after the read response (`rd_valid`) has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a training run |
| cmd_valid | output | 1 | Memory command strobe, one cycle per command |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| wr_data | output | LANES*8 | Training byte for each lane |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | LANES*8 | Read response, one byte per lane |
| dqs_dly | output | LANES*9 | True-strobe delay code per lane |
| dqsn_dly | output | LANES*9 | Complement-strobe delay code per lane |
| lane_err | output | LANES | Per-lane error flag |
| lane_warn | output | LANES | Per-lane warning flag |
| lane_stat | output | LANES*4 | Per-lane stage code, meaningful when its error flag is set |
| train_done | output | 1 | Run finished |
| train_err | output | 1 | OR of all lane error flags |

## Verification
A memory model in the bench gives each lane its own passing window of codes. The windows are of several kinds:
- Asymmetric windows of different widths show whether the two edges are searched and the midpoint is rounded correctly for each lane independently.
- Windows that reach past code 0 or past code 511 separate the limit-hit warning from a normal edge.
- A window that excludes the starting code triggers the initial-compare error.
- A zero-width window at the starting code checks that both searches stop after one step.
- A symmetric window whose midpoint is the starting code, together with a corrupted second read at that code, drives the confirm error.

Randomized windows, a start pulse injected during a run, and variable read latency then test whether lanes stay independent, whether the sequencer waits for the slowest lane, and whether the settle gap holds.

// File: rtl/rdeye_pkg.sv
package rdeye_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHECK,
    PH_LEFT,
    PH_RIGHT,
    PH_CONFIRM,
    PH_DONE,
    PH_FAIL
  } lane_ph_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_SETTLE,
    SQ_READ,
    SQ_WAIT,
    SQ_CHECK
  } seq_st_t;

  localparam logic [3:0] STAT_INIT_MISS = 4'b0000;
  localparam logic [3:0] STAT_CONF_MISS = 4'b0101;

endpackage

// File: rtl/rdeye_lane.sv
module rdeye_lane
  import rdeye_pkg::*;
#(
  parameter int          CW        = 9,
  parameter int          DW        = 8,
  parameter int          INIT_CODE = 256,
  parameter logic [DW-1:0] PATTERN = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          eval,
  input  logic [DW-1:0] rd_byte,
  output logic [CW-1:0] dqs_code,
  output logic [CW-1:0] dqsn_code,
  output logic          err,
  output logic          warn,
  output logic [3:0]    stat,
  output logic          fin
);

  localparam logic [CW-1:0] MAXC  = {CW{1'b1}};
  localparam logic [CW-1:0] INITC = CW'(INIT_CODE);

  lane_ph_t      ph_q, ph_d;
  logic [CW-1:0] code_q, code_d, coden_q, left_q, left_d;
  logic          err_q, err_d, warn_q, warn_d;
  logic [3:0]    stat_q, stat_d;
  logic          pass, active, code_en;
  logic [CW-1:0] rgt_edge;
  logic [CW:0]   sum;
  logic [CW-1:0] mid;

  assign pass     = (rd_byte == PATTERN);
  assign active   = (ph_q != PH_IDLE) && (ph_q != PH_DONE) && (ph_q != PH_FAIL);
  assign rgt_edge = pass ? MAXC : (code_q - 1'b1);
  assign sum      = {1'b0, left_q} + {1'b0, rgt_edge};
  assign mid      = sum[CW:1];

  always_comb begin
    ph_d   = ph_q;
    code_d = code_q;
    left_d = left_q;
    err_d  = err_q;
    warn_d = warn_q;
    stat_d = stat_q;
    if (clr) begin
      ph_d   = PH_CHECK;
      code_d = INITC;
      left_d = INITC;
      err_d  = 1'b0;
      warn_d = 1'b0;
      stat_d = 4'd0;
    end else if (eval && active) begin
      unique case (ph_q)
        PH_CHECK: begin
          if (pass) begin
            ph_d   = PH_LEFT;
            code_d = INITC - 1'b1;
          end else begin
            ph_d   = PH_FAIL;
            err_d  = 1'b1;
            stat_d = STAT_INIT_MISS;
          end
        end
        PH_LEFT: begin
          if (pass && code_q == '0) begin
            left_d = '0;
            warn_d = 1'b1;
            ph_d   = PH_RIGHT;
            code_d = INITC + 1'b1;
          end else if (pass) begin
            code_d = code_q - 1'b1;
          end else begin
            left_d = code_q + 1'b1;
            ph_d   = PH_RIGHT;
            code_d = INITC + 1'b1;
          end
        end
        PH_RIGHT: begin
          if (pass && code_q != MAXC) begin
            code_d = code_q + 1'b1;
          end else begin
            if (pass) warn_d = 1'b1;
            code_d = mid;
            ph_d   = PH_CONFIRM;
          end
        end
        PH_CONFIRM: begin
          if (pass) begin
            ph_d = PH_DONE;
          end else begin
            ph_d   = PH_FAIL;
            err_d  = 1'b1;
            stat_d = STAT_CONF_MISS;
          end
        end
        default: ph_d = ph_q;
      endcase
    end
  end

  assign code_en = clr | (eval & active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      code_q  <= INITC;
      coden_q <= INITC;
      left_q  <= INITC;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
      stat_q  <= 4'd0;
    end else if (code_en) begin
      ph_q    <= ph_d;
      code_q  <= code_d;
      coden_q <= code_d;
      left_q  <= left_d;
      err_q   <= err_d;
      warn_q  <= warn_d;
      stat_q  <= stat_d;
    end
  end

  assign dqs_code  = code_q;
  assign dqsn_code = coden_q;
  assign err       = err_q;
  assign warn      = warn_q;
  assign stat      = stat_q;
  assign fin       = (ph_q == PH_DONE) || (ph_q == PH_FAIL);

  // R4 and R7: a failed lane freezes its delay and stage code until a new run
  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> ($stable(code_q) && $stable(stat_q) && err_q));

  // R7: only the two defined stage codes accompany an error
  assert_stat_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (stat_q == STAT_INIT_MISS || stat_q == STAT_CONF_MISS));

  // R5: both strobe delay registers carry the same code
  assert_both_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_q == coden_q);

endmodule

// File: rtl/rdeye_seq.sv
module rdeye_seq
  import rdeye_pkg::*;
#(
  parameter int LANES  = 9,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_valid,
  input  logic [LANES-1:0] lane_fin,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic             lane_clr,
  output logic             lane_eval,
  output logic             done
);

  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE - 1);

  seq_st_t       st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en, done_q, done_d, done_en, busy;

  assign busy = (st_q != SQ_IDLE);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    lane_clr  = 1'b0;
    lane_eval = 1'b0;
    done_d    = done_q;
    done_en   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d     = SQ_WRITE;
          lane_clr = 1'b1;
          done_d   = 1'b0;
          done_en  = 1'b1;
        end
      end
      SQ_WRITE: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        st_d      = SQ_SETTLE;
        cnt_d     = '0;
        cnt_en    = 1'b1;
      end
      SQ_SETTLE: begin
        if (cnt_q == SLAST) begin
          st_d = SQ_READ;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      SQ_READ: begin
        cmd_valid = 1'b1;
        st_d      = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (rd_valid) begin
          lane_eval = 1'b1;
          st_d      = SQ_CHECK;
        end
      end
      SQ_CHECK: begin
        if (&lane_fin) begin
          st_d    = SQ_IDLE;
          done_d  = 1'b1;
          done_en = 1'b1;
        end else begin
          st_d   = SQ_SETTLE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  assign done = done_q;

  // R11: each command lasts a single cycle
  assert_cmd_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R3: a start during a run never leads to a write command
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(cmd_valid && cmd_write));

  // R9: completion only once every lane has finished
  assert_done_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&lane_fin));

endmodule

// File: rtl/rdeye_train.sv
module rdeye_train
  import rdeye_pkg::*;
#(
  parameter int            LANES     = 9,
  parameter int            CW        = 9,
  parameter int            DW        = 8,
  parameter int            SETTLE    = 4,
  parameter int            INIT_CODE = 256,
  parameter logic [DW-1:0] PATTERN   = 8'hA5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                cmd_valid,
  output logic                cmd_write,
  output logic [LANES*DW-1:0] wr_data,
  input  logic                rd_valid,
  input  logic [LANES*DW-1:0] rd_data,
  output logic [LANES*CW-1:0] dqs_dly,
  output logic [LANES*CW-1:0] dqsn_dly,
  output logic [LANES-1:0]    lane_err,
  output logic [LANES-1:0]    lane_warn,
  output logic [LANES*4-1:0]  lane_stat,
  output logic                train_done,
  output logic                train_err
);

  logic             lane_clr, lane_eval;
  logic [LANES-1:0] lane_fin;

  rdeye_seq #(.LANES(LANES), .SETTLE(SETTLE)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_valid  (rd_valid),
    .lane_fin  (lane_fin),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .lane_clr  (lane_clr),
    .lane_eval (lane_eval),
    .done      (train_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdeye_lane #(
      .CW(CW), .DW(DW), .INIT_CODE(INIT_CODE), .PATTERN(PATTERN)
    ) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (lane_clr),
      .eval      (lane_eval),
      .rd_byte   (rd_data[g*DW +: DW]),
      .dqs_code  (dqs_dly[g*CW +: CW]),
      .dqsn_code (dqsn_dly[g*CW +: CW]),
      .err       (lane_err[g]),
      .warn      (lane_warn[g]),
      .stat      (lane_stat[g*4 +: 4]),
      .fin       (lane_fin[g])
    );
    assign wr_data[g*DW +: DW] = PATTERN;
  end

  assign train_err = |lane_err;

endmodule

// File: tb/rdeye_train_tb_top.sv
`timescale 1ns/1ps
module rdeye_train_tb_top;

  localparam int L      = 9;
  localparam int SETTLE = 4;
  localparam int INIT   = 256;
  localparam logic [7:0] PAT = 8'hA5;

  logic           clk, rst_n, start;
  logic           cmd_valid, cmd_write, rd_valid;
  logic [L*8-1:0] wr_data, rd_data;
  logic [L*9-1:0] dqs_dly, dqsn_dly;
  logic [L-1:0]   lane_err, lane_warn;
  logic [L*4-1:0] lane_stat;
  logic           train_done, train_err;

  rdeye_train #(.LANES(L), .SETTLE(SETTLE), .INIT_CODE(INIT), .PATTERN(PAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dqs_dly(dqs_dly), .dqsn_dly(dqsn_dly),
    .lane_err(lane_err), .lane_warn(lane_warn), .lane_stat(lane_stat),
    .train_done(train_done), .train_err(train_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int lo[L];
  int hi[L];
  bit cbad[L];
  int writes, reads, min_gap, last_ev, cyc;
  bit write_bad;
  logic [L*8-1:0] mem;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model with per-lane passing windows
  initial begin
    bit pend;
    int cnt;
    logic [L*8-1:0] held;
    pend = 0; cnt = 0; cyc = 0; rd_valid = 1'b0; rd_data = '0; mem = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_valid = 1'b0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = held;
          pend     = 0;
          last_ev  = cyc;
        end
      end
      if (rst_n && cmd_valid) begin
        if (cmd_write) begin
          mem = wr_data;
          writes++;
          if (reads != 0) write_bad = 1;
          last_ev = cyc;
        end else begin
          if (cyc - last_ev < min_gap) min_gap = cyc - last_ev;
          for (int l = 0; l < L; l++) begin
            int c;
            bit ok;
            c  = int'(dqs_dly[l*9 +: 9]);
            ok = (c >= lo[l]) && (c <= hi[l]) && !(cbad[l] && c == INIT && reads > 0);
            held[l*8 +: 8] = ok ? mem[l*8 +: 8] : ~mem[l*8 +: 8];
          end
          reads++;
          pend = 1;
          cnt  = 1 + $urandom_range(0, 3);
        end
      end
    end
  end

  function automatic void model(int l, output int c, output bit w, output bit e,
                                output int s);
    int a, b;
    if (INIT < lo[l] || INIT > hi[l]) begin
      c = INIT; w = 0; e = 1; s = 0;
      return;
    end
    a = (lo[l] < 0) ? 0 : lo[l];
    b = (hi[l] > 511) ? 511 : hi[l];
    w = (a == 0) || (b == 511);
    c = (a + b) >> 1;
    e = 0; s = 0;
    if (cbad[l] && c == INIT) begin
      e = 1; s = 5;
    end
  endfunction

  task automatic run(bit inject_start);
    int  ec, es, n;
    bit  ew, ee, anyerr;
    writes = 0; reads = 0; min_gap = 1000000; write_bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: flags and done cleared once the start has been taken
    chk(train_done == 1'b0, "R2", "done cleared", int'(train_done), 0);
    chk(lane_err == '0 && lane_warn == '0, "R2", "flags cleared",
        int'(lane_err | lane_warn), 0);
    n = 0;
    while (train_done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (inject_start && n == 40) start = 1'b1;   // R3: start during a run
      if (inject_start && n == 41) start = 1'b0;
    end
    anyerr = 0;
    for (int l = 0; l < L; l++) begin
      model(l, ec, ew, ee, es);
      anyerr |= ee;
      chk(int'(dqs_dly[l*9 +: 9]) == ec, "R5", $sformatf("lane %0d dqs code", l),
          int'(dqs_dly[l*9 +: 9]), ec);
      chk(int'(dqsn_dly[l*9 +: 9]) == ec, "R5", $sformatf("lane %0d dqsn code", l),
          int'(dqsn_dly[l*9 +: 9]), ec);
      chk(lane_warn[l] == ew, "R6", $sformatf("lane %0d warn", l), int'(lane_warn[l]), int'(ew));
      chk(lane_err[l] == ee, "R4", $sformatf("lane %0d err", l), int'(lane_err[l]), int'(ee));
      if (ee)
        chk(int'(lane_stat[l*4 +: 4]) == es, "R7", $sformatf("lane %0d stage", l),
            int'(lane_stat[l*4 +: 4]), es);
    end
    chk(train_err == anyerr, "R10", "global err", int'(train_err), int'(anyerr));
    chk(writes == 1 && !write_bad, "R3", "one write per run", writes, 1);
    chk(min_gap >= SETTLE + 1, "R8", "settle gap", min_gap, SETTLE + 1);
    repeat (20) @(negedge clk);
    chk(train_done == 1'b1 && cmd_valid == 1'b0, "R9", "done held, idle",
        int'(train_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    start = 1'b0;
    rst_n = 1'b0;
    for (int l = 0; l < L; l++) begin lo[l] = 0; hi[l] = 511; cbad[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(train_done == 0 && train_err == 0 && cmd_valid == 0, "R1", "idle outputs",
        int'({train_done, train_err, cmd_valid}), 0);
    chk(lane_err == '0 && lane_warn == '0, "R1", "lane flags", int'(lane_err | lane_warn), 0);
    for (int l = 0; l < L; l++)
      chk(int'(dqs_dly[l*9 +: 9]) == INIT, "R1", $sformatf("lane %0d reset code", l),
          int'(dqs_dly[l*9 +: 9]), INIT);

    // directed: distinct asymmetric windows per lane
    for (int l = 0; l < L; l++) begin
      lo[l] = 256 - 10 - 3 * l; hi[l] = 256 + 20 + 5 * l; cbad[l] = 0;
    end
    run(0);

    // directed: limit hits (R6), zero-width window
    lo[0] = -5;  hi[0] = 300;
    lo[1] = 180; hi[1] = 600;
    lo[2] = 0;   hi[2] = 511;
    lo[3] = 256; hi[3] = 256;
    run(0);

    // directed: initial miss (R4), confirm miss (R7) on lanes with prior errors cleared next
    lo[4] = 300; hi[4] = 400;
    lo[5] = 0;   hi[5] = 100;
    lo[6] = 200; hi[6] = 312; cbad[6] = 1;
    lo[7] = -9;  hi[7] = 521; cbad[7] = 1;
    run(0);

    // R3: start injected during a run, R2 clearing after an errored run
    for (int l = 0; l < L; l++) begin
      lo[l] = 240 - 7 * l; hi[l] = 262 + 11 * l; cbad[l] = 0;
    end
    run(1);

    // random windows
    for (int r = 0; r < 5; r++) begin
      for (int l = 0; l < L; l++) begin
        int k;
        k = $urandom_range(0, 7);
        cbad[l] = 0;
        if (k == 0) begin
          lo[l] = 300 + $urandom_range(0, 100); hi[l] = lo[l] + 50;
        end else if (k == 1) begin
          int d;
          d = $urandom_range(0, 200);
          lo[l] = 256 - d; hi[l] = 256 + d; cbad[l] = 1;
        end else begin
          lo[l] = $urandom_range(0, 256) - (($urandom_range(0, 5) == 0) ? 30 : 0);
          hi[l] = 256 + $urandom_range(0, 255) + (($urandom_range(0, 5) == 0) ? 30 : 0);
        end
      end
      run(r == 2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule